// File: doc/BRIEF.md
# DMA Trigger Source Selector

This block decides, separately for each of four DMA channels, which hardware event kicks off a transfer. Every channel holds a 4-bit select code. The code picks one candidate from that channel's own list. The list holds a software start bit, the falling or rising edge of an asynchronous active-low request pin, four port event lines, two timer compare matches, serial buffer status, audio and SPI transfer requests, and converter completion. When the chosen event occurs and the channel's DMA enable input is high, the block emits a one-cycle start pulse for that channel.

The same start also produces a matching CPU interrupt request. That request comes out a fixed two clocks after the start, so the transfer and the interrupt handler can run side by side. No interrupt flag, mask, priority or request setting enters this block, so none of them can hold back a start.

Software writes a select code by pulsing `cfg_we` with a channel number and a code. All four codes can be read back at any time. The software start bits are written through a separate strobe. Every event input is a plain synchronous one-cycle pulse, and every output is a plain pulse, so there is no handshake and no back-pressure.

Top module: `dts_trig_select`

## Requirements
- R1: After reset every channel's select code reads 0000, and `dma_start` and `cpu_irq` are all low.
- R2: With code 0000, a `sw_we` cycle whose `sw_data` bit for the channel is 1 gives exactly one start pulse on the second rising edge after the write. The bit then clears by itself. Several channels may be started in the same write.
- R3: The request pin is passed through two synchronizing flops before edge detection. Code 0001 starts the channel on a high-to-low change of `ext_req_n` and code 0010 on a low-to-high change, each with exactly one pulse, on the third rising edge after the pin changes. The opposite edge gives no pulse.
- R4: For channel c, the port event lines are selected as follows: code 0011 selects `port_evt[c]`, 0100 selects `port_evt[c+4]`, 1101 selects `port_evt[c+8]` and 1110 selects `port_evt[c+12]`.
- R5: Code 0110 selects `tmr_cmp_b[c]`, 0111 selects `tmr_cmp_a[c]`, and 1100 selects `adc_done` on every channel.
- R6: Code 1000 selects `aud_in_l` on channel 2 and `aud_in_r` on channel 3. Code 1001 selects `aud_out_l`, `aud_out_r`, `spi_tx_req` and `spi_rx_req` on channels 0 to 3 in that order. Code 1010 selects `sio_rx_full[c]` and code 1011 selects `sio_tx_empty[c]` on channels 0 to 2.
- R7: The reserved codes never start a channel. These are 0101 and 1111 on all channels, 1000 on channels 0 and 1, and 1010 and 1011 on channel 3.
- R8: A pulse from a synchronous source reaches `dma_start` on the first rising edge where it is high, and only if the channel's `dma_en` bit is high at that edge. Otherwise it is dropped.
- R9: `cpu_irq[c]` pulses exactly two clocks after each `dma_start[c]` pulse, once per start and never otherwise.
- R10: On an edge where a select write to channel c is taken, channel c produces no start, from either the old or the new code. The new code is read back on `sel_q` right after that edge, and other channels are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Select code write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 4 | Select code to write |
| sel_q | output | 16 | Read back of all codes, channel c in bits 4c+3:4c |
| sw_we | input | 1 | Software start write strobe |
| sw_data | input | 4 | Software start bits, one per channel |
| dma_en | input | 4 | Per-channel DMA enable |
| ext_req_n | input | 4 | Asynchronous active-low request pins, idle high |
| port_evt | input | 16 | Port event pulses |
| tmr_cmp_a | input | 4 | Timer compare A match, one per channel |
| tmr_cmp_b | input | 4 | Timer compare B match, one per channel |
| sio_rx_full | input | 3 | Serial receive buffer full, channels 0 to 2 |
| sio_tx_empty | input | 3 | Serial transmit buffer empty, channels 0 to 2 |
| aud_out_l | input | 1 | Audio output left request |
| aud_out_r | input | 1 | Audio output right request |
| aud_in_l | input | 1 | Audio input left request |
| aud_in_r | input | 1 | Audio input right request |
| spi_tx_req | input | 1 | SPI transmit DMA request |
| spi_rx_req | input | 1 | SPI receive DMA request |
| adc_done | input | 1 | Converter completion pulse |
| dma_start | output | 4 | One-cycle DMA start per channel |
| cpu_irq | output | 4 | CPU interrupt request, two clocks after the start |

## Verification
Each result has a fixed latency, and the bench samples it on the falling edge where it is due. A synchronous source pulse shows on `dma_start` after the first rising edge. A software start shows after the second edge, a pin change after the third, and `cpu_irq` two edges after the start. The sweep drives every source on every channel under every code. It checks the start in its due cycle and the start is gone one cycle later, and it checks the interrupt in its due cycle and one cycle later. The pin edges, software starts and write blanking are checked by counting pulses over a window and recording the cycle of the first one, so an early, late or repeated pulse is caught.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int TRIG_W    = 4;
  localparam int NUM_CODES = 1 << TRIG_W;

  typedef enum logic [TRIG_W-1:0] {
    TS_SOFT     = 4'd0,
    TS_EXT_FALL = 4'd1,
    TS_EXT_RISE = 4'd2,
    TS_PORT_A   = 4'd3,
    TS_PORT_B   = 4'd4,
    TS_HOLE_5   = 4'd5,
    TS_TMR_B    = 4'd6,
    TS_TMR_A    = 4'd7,
    TS_AUDIO    = 4'd8,
    TS_STREAM   = 4'd9,
    TS_SIO_RX   = 4'd10,
    TS_SIO_TX   = 4'd11,
    TS_ADC      = 4'd12,
    TS_PORT_C   = 4'd13,
    TS_PORT_D   = 4'd14,
    TS_HOLE_15  = 4'd15
  } trig_code_e;

  // Codes that must never start the given channel
  function automatic logic code_reserved(input int unsigned ch,
                                         input logic [TRIG_W-1:0] code);
    case (code)
      TS_HOLE_5, TS_HOLE_15: return 1'b1;
      TS_AUDIO:              return (ch < 2);
      TS_SIO_RX, TS_SIO_TX:  return (ch == 3);
      default:               return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dts_sel_regs.sv
module dts_sel_regs
  import dts_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CH_W-1:0]              wr_ch,
  input  logic [TRIG_W-1:0]            wr_code,
  output logic [NUM_CH-1:0][TRIG_W-1:0] sel,
  output logic [NUM_CH-1:0]            wr_hit
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_ch == CH_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) sel[i] <= TS_SOFT;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_hit[i]) sel[i] <= wr_code;
      end
    end
  end
endmodule

// File: rtl/dts_ext_edge.sv
module dts_ext_edge #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_n,
  output logic [NUM_CH-1:0] fall,
  output logic [NUM_CH-1:0] rise
);
  logic [NUM_CH-1:0] meta_q, sync_q, prev_q;

  // Idle level of the pins is high; reset to it so no edge appears
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= req_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall = prev_q & ~sync_q;
  assign rise = ~prev_q & sync_q;
endmodule

// File: rtl/dts_chan.sv
module dts_chan
  import dts_pkg::*;
#(
  parameter int CH_IDX  = 0,
  parameter int IRQ_LAG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TRIG_W-1:0]    sel,
  input  logic [NUM_CODES-1:0] cand,
  input  logic                 en,
  input  logic                 blank,
  output logic                 start,
  output logic                 irq
);
  logic              hit;
  logic [IRQ_LAG-1:0] lag_q;

  assign hit = cand[sel] & ~code_reserved(CH_IDX, sel);

  always_ff @(posedge clk) begin
    if (!rst_n) start <= 1'b0;
    else        start <= hit & en & ~blank;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lag_q <= '0;
    end else begin
      lag_q[0] <= start;
      for (int i = 1; i < IRQ_LAG; i++) lag_q[i] <= lag_q[i-1];
    end
  end

  assign irq = lag_q[IRQ_LAG-1];
endmodule

// File: rtl/dts_trig_select.sv
module dts_trig_select
  import dts_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int IRQ_LAG = 2,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PORT_W = 4 * NUM_CH,
  localparam int SIO_N  = NUM_CH - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic [TRIG_W-1:0]        cfg_sel,
  output logic [NUM_CH*TRIG_W-1:0] sel_q,
  input  logic                     sw_we,
  input  logic [NUM_CH-1:0]        sw_data,
  input  logic [NUM_CH-1:0]        dma_en,
  input  logic [NUM_CH-1:0]        ext_req_n,
  input  logic [PORT_W-1:0]        port_evt,
  input  logic [NUM_CH-1:0]        tmr_cmp_a,
  input  logic [NUM_CH-1:0]        tmr_cmp_b,
  input  logic [SIO_N-1:0]         sio_rx_full,
  input  logic [SIO_N-1:0]         sio_tx_empty,
  input  logic                     aud_out_l,
  input  logic                     aud_out_r,
  input  logic                     aud_in_l,
  input  logic                     aud_in_r,
  input  logic                     spi_tx_req,
  input  logic                     spi_rx_req,
  input  logic                     adc_done,
  output logic [NUM_CH-1:0]        dma_start,
  output logic [NUM_CH-1:0]        cpu_irq
);
  logic [NUM_CH-1:0][TRIG_W-1:0] sel;
  logic [NUM_CH-1:0]             wr_hit;
  logic [NUM_CH-1:0]             ext_fall, ext_rise;
  logic [NUM_CH-1:0]             sw_pend;

  dts_sel_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_ch  (cfg_ch),
    .wr_code(cfg_sel),
    .sel    (sel),
    .wr_hit (wr_hit)
  );

  assign sel_q = sel;

  dts_ext_edge #(.NUM_CH(NUM_CH)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .req_n(ext_req_n),
    .fall (ext_fall),
    .rise (ext_rise)
  );

  // Write-one-to-start bits; held for exactly one cycle
  always_ff @(posedge clk) begin
    if (!rst_n)     sw_pend <= '0;
    else if (sw_we) sw_pend <= sw_data;
    else            sw_pend <= '0;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic                 src_aud, src_strm, src_rx, src_tx;
    logic [NUM_CODES-1:0] cand;

    if (g == 2)      begin : g_a8 assign src_aud = aud_in_l; end
    else if (g == 3) begin : g_a8 assign src_aud = aud_in_r; end
    else             begin : g_a8 assign src_aud = 1'b0;     end

    if (g == 0)      begin : g_a9 assign src_strm = aud_out_l;  end
    else if (g == 1) begin : g_a9 assign src_strm = aud_out_r;  end
    else if (g == 2) begin : g_a9 assign src_strm = spi_tx_req; end
    else if (g == 3) begin : g_a9 assign src_strm = spi_rx_req; end
    else             begin : g_a9 assign src_strm = 1'b0;       end

    if (g < SIO_N) begin : g_sio
      assign src_rx = sio_rx_full[g];
      assign src_tx = sio_tx_empty[g];
    end else begin : g_sio
      assign src_rx = 1'b0;
      assign src_tx = 1'b0;
    end

    // Bit k of cand is the source chosen by code k
    assign cand = {1'b0,
                   port_evt[g+12], port_evt[g+8], adc_done,
                   src_tx, src_rx, src_strm, src_aud,
                   tmr_cmp_a[g], tmr_cmp_b[g], 1'b0,
                   port_evt[g+4], port_evt[g],
                   ext_rise[g], ext_fall[g], sw_pend[g]};

    dts_chan #(.CH_IDX(g), .IRQ_LAG(IRQ_LAG)) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (sel[g]),
      .cand (cand),
      .en   (dma_en[g]),
      .blank(wr_hit[g]),
      .start(dma_start[g]),
      .irq  (cpu_irq[g])
    );
  end
endmodule

// File: rtl/dts_chk.sv
module dts_chk
  import dts_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [CH_W-1:0]          cfg_ch,
  input logic [NUM_CH-1:0]        dma_en,
  input logic [NUM_CH-1:0]        dma_start,
  input logic [NUM_CH-1:0]        cpu_irq,
  input logic [NUM_CH*TRIG_W-1:0] sel_q
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 3)  age <= age + 2'd1;
  end

  // R9
  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2) |-> (cpu_irq == $past(dma_start, 2)));

  // R8
  p_en_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 1) |-> ((dma_start & ~$past(dma_en)) == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    // R7
    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 1 && code_reserved(g, $past(sel_q[g*TRIG_W +: TRIG_W])))
      |-> !dma_start[g]);

    // R10
    p_write_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 1 && $past(cfg_we) && $past(cfg_ch) == CH_W'(g))
      |-> !dma_start[g]);

    // R3
    p_edge_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_start[g] && !cfg_we &&
       (sel_q[g*TRIG_W +: TRIG_W] == TS_EXT_FALL ||
        sel_q[g*TRIG_W +: TRIG_W] == TS_EXT_RISE))
      |=> !dma_start[g]);
  end
endmodule

bind dts_trig_select dts_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_ch   (cfg_ch),
  .dma_en   (dma_en),
  .dma_start(dma_start),
  .cpu_irq  (cpu_irq),
  .sel_q    (sel_q)
);

// File: tb/dts_trig_select_tb.sv
module dts_trig_select_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] sel_q;
  logic        sw_we = 1'b0;
  logic [3:0]  sw_data = '0;
  logic [3:0]  dma_en = 4'hF;
  logic [3:0]  ext_req_n = 4'hF;
  logic [15:0] port_evt = '0;
  logic [3:0]  tmr_cmp_a = '0, tmr_cmp_b = '0;
  logic [2:0]  sio_rx_full = '0, sio_tx_empty = '0;
  logic        aud_out_l = 0, aud_out_r = 0, aud_in_l = 0, aud_in_r = 0;
  logic        spi_tx_req = 0, spi_rx_req = 0, adc_done = 0;
  logic [3:0]  dma_start, cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dts_trig_select u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .sel_q(sel_q), .sw_we(sw_we), .sw_data(sw_data),
    .dma_en(dma_en), .ext_req_n(ext_req_n), .port_evt(port_evt),
    .tmr_cmp_a(tmr_cmp_a), .tmr_cmp_b(tmr_cmp_b),
    .sio_rx_full(sio_rx_full), .sio_tx_empty(sio_tx_empty),
    .aud_out_l(aud_out_l), .aud_out_r(aud_out_r),
    .aud_in_l(aud_in_l), .aud_in_r(aud_in_r),
    .spi_tx_req(spi_tx_req), .spi_rx_req(spi_rx_req),
    .adc_done(adc_done), .dma_start(dma_start), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic write_sel(input int ch, input int code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 4'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // 0..15 port, 16..19 cmp B, 20..23 cmp A, 24..26 rx, 27..29 tx,
  // 30 aud out L, 31 aud out R, 32 aud in L, 33 aud in R, 34 spi tx, 35 spi rx, 36 adc
  task automatic drive_src(input int s, input logic v);
    if (s < 16)      port_evt[s] = v;
    else if (s < 20) tmr_cmp_b[s-16] = v;
    else if (s < 24) tmr_cmp_a[s-20] = v;
    else if (s < 27) sio_rx_full[s-24] = v;
    else if (s < 30) sio_tx_empty[s-27] = v;
    else case (s)
      30: aud_out_l = v;
      31: aud_out_r = v;
      32: aud_in_l = v;
      33: aud_in_r = v;
      34: spi_tx_req = v;
      35: spi_rx_req = v;
      default: adc_done = v;
    endcase
  endtask

  function automatic int exp_code(input int ch, input int s);
    if (s < 16) begin
      if (s == ch)      return 3;
      if (s == ch + 4)  return 4;
      if (s == ch + 8)  return 13;
      if (s == ch + 12) return 14;
      return -1;
    end
    if (s < 20) return (s - 16 == ch) ? 6 : -1;
    if (s < 24) return (s - 20 == ch) ? 7 : -1;
    if (s < 27) return (s - 24 == ch) ? 10 : -1;
    if (s < 30) return (s - 27 == ch) ? 11 : -1;
    case (s)
      30: return (ch == 0) ? 9 : -1;
      31: return (ch == 1) ? 9 : -1;
      32: return (ch == 2) ? 8 : -1;
      33: return (ch == 3) ? 8 : -1;
      34: return (ch == 2) ? 9 : -1;
      35: return (ch == 3) ? 9 : -1;
      default: return 12;
    endcase
  endfunction

  function automatic string req_tag(input int ch, input int code);
    if (code == 5 || code == 15 || (code == 8 && ch < 2) ||
        ((code == 10 || code == 11) && ch == 3)) return "R7";
    case (code)
      0:                return "R2";
      1, 2:             return "R3";
      3, 4, 13, 14:     return "R4";
      6, 7, 12:         return "R5";
      default:          return "R6";
    endcase
  endfunction

  // Counts start pulses on channel ch over n cycles; first = cycle of first
  task automatic watch(input int ch, input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (dma_start[ch]) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    int cnt, first;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "select codes", 32'(sel_q), 32'h0);
    chk("R1", "start", 32'(dma_start), 32'h0);
    chk("R1", "irq", 32'(cpu_irq), 32'h0);

    // Full sweep: channel x code x synchronous source
    for (int ch = 0; ch < 4; ch++) begin
      for (int code = 0; code < 16; code++) begin
        for (int c = 0; c < 4; c++) write_sel(c, (c == ch) ? code : 5);
        for (int s = 0; s < 37; s++) begin
          logic [3:0] e;
          e = (exp_code(ch, s) == code) ? 4'(1 << ch) : 4'h0;
          @(negedge clk); drive_src(s, 1'b1);
          @(negedge clk); drive_src(s, 1'b0);
          chk(req_tag(ch, code), $sformatf("start ch%0d code%0d src%0d", ch, code, s),
              32'(dma_start), 32'(e));
          @(negedge clk);
          chk("R8", "start lasts one cycle", 32'(dma_start), 32'h0);
          @(negedge clk);
          chk("R9", $sformatf("irq ch%0d code%0d src%0d", ch, code, s), 32'(cpu_irq), 32'(e));
          @(negedge clk);
          chk("R9", "irq lasts one cycle", 32'(cpu_irq), 32'h0);
        end
      end
    end

    // R2: software start
    for (int c = 0; c < 4; c++) write_sel(c, 0);
    for (int ch = 0; ch < 4; ch++) begin
      @(negedge clk); sw_we = 1'b1; sw_data = 4'(1 << ch);
      @(negedge clk); sw_we = 1'b0; sw_data = '0;
      chk("R2", "software start not yet", 32'(dma_start), 32'h0);
      watch(ch, 6, cnt, first);
      chk("R2", "software start count", 32'(cnt), 32'd1);
      chk("R2", "software start cycle", 32'(first), 32'd1);
    end
    @(negedge clk); sw_we = 1'b1; sw_data = 4'b1010;
    @(negedge clk); sw_we = 1'b0; sw_data = '0;
    @(negedge clk);
    chk("R2", "two channels at once", 32'(dma_start), 32'hA);
    @(negedge clk);
    chk("R2", "self-cleared", 32'(dma_start), 32'h0);

    // R3: request pin edges
    for (int ch = 0; ch < 4; ch++) begin
      for (int c = 0; c < 4; c++) write_sel(c, (c == ch) ? 1 : 5);
      @(negedge clk); ext_req_n[ch] = 1'b0;
      watch(ch, 8, cnt, first);
      chk("R3", $sformatf("fall count ch%0d", ch), 32'(cnt), 32'd1);
      chk("R3", $sformatf("fall cycle ch%0d", ch), 32'(first), 32'd3);
      @(negedge clk); ext_req_n[ch] = 1'b1;
      watch(ch, 8, cnt, first);
      chk("R3", "rise ignored under fall code", 32'(cnt), 32'd0);
      write_sel(ch, 2);
      @(negedge clk); ext_req_n[ch] = 1'b0;
      watch(ch, 8, cnt, first);
      chk("R3", "fall ignored under rise code", 32'(cnt), 32'd0);
      @(negedge clk); ext_req_n[ch] = 1'b1;
      watch(ch, 8, cnt, first);
      chk("R3", $sformatf("rise count ch%0d", ch), 32'(cnt), 32'd1);
      chk("R3", $sformatf("rise cycle ch%0d", ch), 32'(first), 32'd3);
    end

    // R8: enable gating
    for (int c = 0; c < 4; c++) write_sel(c, 3);
    @(negedge clk); dma_en = 4'b1110; port_evt[3:0] = 4'hF;
    @(negedge clk); port_evt = '0;
    chk("R8", "disabled channel dropped", 32'(dma_start), 32'hE);
    @(negedge clk); @(negedge clk);
    chk("R8", "no irq for dropped start", 32'(cpu_irq), 32'hE);
    dma_en = 4'hF;

    // R10: write blanking
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'd0; cfg_sel = 4'd4; port_evt[0] = 1'b1; port_evt[4] = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; port_evt = '0;
    chk("R10", "no start during write", 32'(dma_start), 32'h0);
    chk("R10", "new code readback", 32'(sel_q[3:0]), 32'd4);
    @(negedge clk); port_evt[4] = 1'b1;
    @(negedge clk); port_evt = '0;
    chk("R10", "new source active", 32'(dma_start), 32'h1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'd1; cfg_sel = 4'd3; port_evt[4] = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; port_evt = '0;
    chk("R10", "other channel unaffected", 32'(dma_start), 32'h1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule